// File: doc/BRIEF.md
# Register Renamer with Rename Buffer File

This block renames one register-writing instruction per cycle for a small in-order integer core. A mapping table has one entry per architectural register: a valid flag and a buffer index. A separate rename buffer file holds results until retirement, and an architectural register file holds committed state. At dispatch the destination register receives the next free buffer, and both sources are looked up in the same cycle. For each source the block returns either a ready value or the index of the buffer that will produce it.

A single execution unit writes results back by buffer index. Retirement runs in program order. When the oldest buffer holds a finished result and retirement is requested, the value is copied into the architectural file. The mapping entry for that register is cleared only if it still points at the retiring buffer. Buffers form a circular queue, so allocation order equals retirement order. When every buffer is in use, dispatch is stalled.

Top module: `rename_unit`

## Requirements
- R1: After reset no register is renamed, no buffer is in use, every architectural register reads 0 with ready=1, and the stall output is low.
- R2: An accepted dispatch takes the buffer at the queue tail. Indices run 0,1,...,NUM_BUF-1 and then wrap to 0. The index appears on `disp_tag` in the dispatch cycle, and from the next cycle the destination register maps to that buffer, which is not yet valid.
- R3: `disp_stall` is high exactly when NUM_BUF buffers are in use. A dispatch presented while stalled allocates nothing and renames nothing.
- R4: A source whose register is renamed to a buffer without a result returns ready=0, with the buffer index on its tag output.
- R5: A writeback stores its data in the buffer named by `wb_tag` and marks it valid. Later lookups of a register mapped there return that data with ready=1.
- R6: A writeback in the same cycle as a lookup of its buffer is forwarded, so the lookup returns the writeback data with ready=1.
- R7: A source whose register is not renamed returns the architectural file value with ready=1 and tag 0.
- R8: Renaming a register that is already renamed replaces its buffer index. Lookups then follow the newer buffer.
- R9: With `ret_req` high, the oldest buffer retires (`ret_fire`=1) only if its result was written in an earlier cycle. Retiring copies the result into the architectural file and frees the buffer.
- R10: On retirement the mapping entry is cleared only if it still holds the retiring index. A younger rename of the same register is kept.
- R11: The source lookups of a dispatching instruction see the mapping from before its own destination rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Register-writing instruction presented for dispatch |
| disp_dst | input | AW | Destination architectural register |
| disp_src1 | input | AW | First source register looked up |
| disp_src2 | input | AW | Second source register looked up |
| disp_stall | output | 1 | All rename buffers in use |
| disp_tag | output | BW | Buffer index allocated to the dispatch |
| src1_rdy | output | 1 | First source value available |
| src1_val | output | DATA_W | First source value |
| src1_tag | output | BW | First source buffer index when not ready |
| src2_rdy | output | 1 | Second source value available |
| src2_val | output | DATA_W | Second source value |
| src2_tag | output | BW | Second source buffer index when not ready |
| wb_valid | input | 1 | Result writeback |
| wb_tag | input | BW | Buffer receiving the result |
| wb_data | input | DATA_W | Result value |
| ret_req | input | 1 | Request to retire the oldest instruction |
| ret_fire | output | 1 | Oldest instruction retired this cycle |

## Verification
The hardest case to reach is a retirement that finds its mapping entry already taken over by a younger rename. A close second is a buffer whose old mapping was cleared and which is then reused for another register while still invalid. The bench renames one register twice before retiring the older copy, and checks that lookups still return the newer tag. It then fills the whole queue so that allocation wraps around onto the recycled buffer. Finally it looks up the register that first used that buffer, which must come from the architectural file.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

  // Next position in a circular queue of the given depth.
  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy after one cycle of allocate/free.
  function automatic int unsigned next_count(input int unsigned cnt, input bit add, input bit sub);
    return cnt + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction

endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_BUF  = 4,
  parameter int NRD      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ren_en,
  input  logic [$clog2(NUM_ARCH)-1:0] ren_reg,
  input  logic [$clog2(NUM_BUF)-1:0]  ren_idx,
  input  logic                        clr_en,
  input  logic [$clog2(NUM_ARCH)-1:0] clr_reg,
  input  logic [$clog2(NUM_BUF)-1:0]  clr_idx,
  input  logic [$clog2(NUM_ARCH)-1:0] lk_reg [NRD],
  output logic                        lk_vld [NRD],
  output logic [$clog2(NUM_BUF)-1:0]  lk_idx [NRD]
);
  localparam int AW = $clog2(NUM_ARCH);
  localparam int BW = $clog2(NUM_BUF);

  logic          map_vld [NUM_ARCH];
  logic [BW-1:0] map_idx [NUM_ARCH];

  generate
    for (genvar r = 0; r < NUM_ARCH; r++) begin : g_entry
      wire hit_ren = ren_en && (ren_reg == AW'(r));
      wire hit_clr = clr_en && (clr_reg == AW'(r)) && (map_idx[r] == clr_idx);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          map_vld[r] <= 1'b0;
          map_idx[r] <= '0;
        end else if (hit_ren) begin
          map_vld[r] <= 1'b1;
          map_idx[r] <= ren_idx;
        end else if (hit_clr) begin
          map_vld[r] <= 1'b0;
        end
      end
    end
    for (genvar k = 0; k < NRD; k++) begin : g_look
      assign lk_vld[k] = map_vld[lk_reg[k]];
      assign lk_idx[k] = map_idx[lk_reg[k]];
    end
  endgenerate

  assert_rename_maps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en |=> (map_vld[$past(ren_reg)] && map_idx[$past(ren_reg)] == $past(ren_idx)));

  assert_younger_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && map_vld[clr_reg] && map_idx[clr_reg] != clr_idx) |=> map_vld[$past(clr_reg)]);

endmodule

// File: rtl/rnm_buf_queue.sv
module rnm_buf_queue #(
  parameter int NUM_BUF  = 4,
  parameter int NUM_ARCH = 8,
  parameter int DATA_W   = 16,
  parameter int NRD      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_en,
  input  logic [$clog2(NUM_ARCH)-1:0]   alloc_dst,
  input  logic                          wb_en,
  input  logic [$clog2(NUM_BUF)-1:0]    wb_tag,
  input  logic [DATA_W-1:0]             wb_data,
  input  logic                          free_en,
  output logic [$clog2(NUM_BUF)-1:0]    tail_idx,
  output logic [$clog2(NUM_BUF)-1:0]    head_idx,
  output logic                          full,
  output logic                          empty,
  output logic                          head_vld,
  output logic [DATA_W-1:0]             head_data,
  output logic [$clog2(NUM_ARCH)-1:0]   head_dst,
  output logic [$clog2(NUM_BUF+1)-1:0]  occupancy,
  input  logic [$clog2(NUM_BUF)-1:0]    rd_idx  [NRD],
  output logic                          rd_vld  [NRD],
  output logic [DATA_W-1:0]             rd_data [NRD]
);
  import rnm_pkg::*;
  localparam int AW = $clog2(NUM_ARCH);
  localparam int BW = $clog2(NUM_BUF);
  localparam int CW = $clog2(NUM_BUF + 1);

  logic [BW-1:0]     head_q, tail_q;
  logic [CW-1:0]     count_q;
  logic              buf_vld  [NUM_BUF];
  logic [DATA_W-1:0] buf_data [NUM_BUF];
  logic [AW-1:0]     buf_dst  [NUM_BUF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_en) tail_q <= BW'(wrap_inc(32'(tail_q), NUM_BUF));
      if (free_en)  head_q <= BW'(wrap_inc(32'(head_q), NUM_BUF));
      count_q <= CW'(next_count(32'(count_q), alloc_en, free_en));
    end
  end

  generate
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      wire hit_alloc = alloc_en && (tail_q == BW'(b));
      wire hit_wb    = wb_en && (wb_tag == BW'(b));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          buf_vld[b]  <= 1'b0;
          buf_data[b] <= '0;
          buf_dst[b]  <= '0;
        end else begin
          if (hit_alloc) begin
            buf_vld[b] <= 1'b0;
            buf_dst[b] <= alloc_dst;
          end else if (hit_wb) begin
            buf_vld[b] <= 1'b1;
          end
          if (hit_wb) buf_data[b] <= wb_data;
        end
      end
    end
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      wire fwd = wb_en && (wb_tag == rd_idx[k]);
      assign rd_vld[k]  = buf_vld[rd_idx[k]] || fwd;
      assign rd_data[k] = fwd ? wb_data : buf_data[rd_idx[k]];
    end
  endgenerate

  assign tail_idx  = tail_q;
  assign head_idx  = head_q;
  assign occupancy = count_q;
  assign full      = (count_q == CW'(NUM_BUF));
  assign empty     = (count_q == '0);
  assign head_vld  = buf_vld[head_q];
  assign head_data = buf_data[head_q];
  assign head_dst  = buf_dst[head_q];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(NUM_BUF));

  assert_wb_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> buf_vld[$past(wb_tag)]);

  assert_alloc_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !buf_vld[$past(tail_q)]);

endmodule

// File: rtl/rnm_arch_file.sv
module rnm_arch_file #(
  parameter int NUM_ARCH = 8,
  parameter int DATA_W   = 16,
  parameter int NRD      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_ARCH)-1:0] wr_reg,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [$clog2(NUM_ARCH)-1:0] rd_reg  [NRD],
  output logic [DATA_W-1:0]           rd_data [NRD]
);
  localparam int AW = $clog2(NUM_ARCH);

  logic [DATA_W-1:0] regs [NUM_ARCH];

  generate
    for (genvar r = 0; r < NUM_ARCH; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                          regs[r] <= '0;
        else if (wr_en && wr_reg == AW'(r))  regs[r] <= wr_data;
      end
    end
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd_data[k] = regs[rd_reg[k]];
    end
  endgenerate

  assert_commit_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_reg)] == $past(wr_data));

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_BUF  = 4,
  parameter int DATA_W   = 16,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int BW      = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [AW-1:0]     disp_dst,
  input  logic [AW-1:0]     disp_src1,
  input  logic [AW-1:0]     disp_src2,
  output logic              disp_stall,
  output logic [BW-1:0]     disp_tag,
  output logic              src1_rdy,
  output logic [DATA_W-1:0] src1_val,
  output logic [BW-1:0]     src1_tag,
  output logic              src2_rdy,
  output logic [DATA_W-1:0] src2_val,
  output logic [BW-1:0]     src2_tag,
  input  logic              wb_valid,
  input  logic [BW-1:0]     wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              ret_req,
  output logic              ret_fire
);
  localparam int NRD = 2;
  localparam int CW  = $clog2(NUM_BUF + 1);

  // Named internal events used by the assertions.
  logic              disp_fire;
  logic              q_full, q_empty, q_head_vld;
  logic [BW-1:0]     q_tail, q_head;
  logic [DATA_W-1:0] q_head_data;
  logic [AW-1:0]     q_head_dst;
  logic [CW-1:0]     q_count;

  logic [AW-1:0]     src_reg  [NRD];
  logic              map_vld  [NRD];
  logic [BW-1:0]     map_idx  [NRD];
  logic              buf_vld  [NRD];
  logic [DATA_W-1:0] buf_data [NRD];
  logic [DATA_W-1:0] arf_data [NRD];
  logic              op_rdy   [NRD];
  logic [DATA_W-1:0] op_val   [NRD];
  logic [BW-1:0]     op_tag   [NRD];

  assign src_reg[0] = disp_src1;
  assign src_reg[1] = disp_src2;

  assign disp_fire = disp_valid && !q_full;
  assign ret_fire  = ret_req && !q_empty && q_head_vld;

  rnm_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_BUF(NUM_BUF), .NRD(NRD)) u_map (
    .clk(clk), .rst_n(rst_n),
    .ren_en(disp_fire), .ren_reg(disp_dst), .ren_idx(q_tail),
    .clr_en(ret_fire), .clr_reg(q_head_dst), .clr_idx(q_head),
    .lk_reg(src_reg), .lk_vld(map_vld), .lk_idx(map_idx)
  );

  rnm_buf_queue #(.NUM_BUF(NUM_BUF), .NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .NRD(NRD)) u_bufq (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(disp_fire), .alloc_dst(disp_dst),
    .wb_en(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .free_en(ret_fire),
    .tail_idx(q_tail), .head_idx(q_head), .full(q_full), .empty(q_empty),
    .head_vld(q_head_vld), .head_data(q_head_data), .head_dst(q_head_dst),
    .occupancy(q_count),
    .rd_idx(map_idx), .rd_vld(buf_vld), .rd_data(buf_data)
  );

  rnm_arch_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .NRD(NRD)) u_arf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ret_fire), .wr_reg(q_head_dst), .wr_data(q_head_data),
    .rd_reg(src_reg), .rd_data(arf_data)
  );

  generate
    for (genvar k = 0; k < NRD; k++) begin : g_op
      always_comb begin
        if (map_vld[k]) begin
          op_rdy[k] = buf_vld[k];
          op_val[k] = buf_data[k];
          op_tag[k] = map_idx[k];
        end else begin
          op_rdy[k] = 1'b1;
          op_val[k] = arf_data[k];
          op_tag[k] = '0;
        end
      end
    end
  endgenerate

  assign disp_stall = q_full;
  assign disp_tag   = q_tail;
  assign src1_rdy   = op_rdy[0];
  assign src1_val   = op_val[0];
  assign src1_tag   = op_tag[0];
  assign src2_rdy   = op_rdy[1];
  assign src2_val   = op_val[1];
  assign src2_tag   = op_tag[1];

  assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_stall && !ret_fire) |=> (disp_stall && q_tail == $past(q_tail)));

  assert_retire_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !disp_fire) |=> (q_count == $past(q_count) - CW'(1)));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && map_vld[0] && map_idx[0] == wb_tag) |-> (src1_rdy && src1_val == wb_data));

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!disp_stall && q_count == '0));

endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
  localparam int NUM_ARCH = 8;
  localparam int NUM_BUF  = 4;
  localparam int DATA_W   = 16;
  localparam int AW = $clog2(NUM_ARCH);
  localparam int BW = $clog2(NUM_BUF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [AW-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic disp_stall;
  logic [BW-1:0] disp_tag;
  logic src1_rdy, src2_rdy;
  logic [DATA_W-1:0] src1_val, src2_val;
  logic [BW-1:0] src1_tag, src2_tag;
  logic wb_valid = 1'b0;
  logic [BW-1:0] wb_tag = '0;
  logic [DATA_W-1:0] wb_data = '0;
  logic ret_req = 1'b0;
  logic ret_fire;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rename_unit #(.NUM_ARCH(NUM_ARCH), .NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_src2(disp_src2),
    .disp_stall(disp_stall), .disp_tag(disp_tag),
    .src1_rdy(src1_rdy), .src1_val(src1_val), .src1_tag(src1_tag),
    .src2_rdy(src2_rdy), .src2_val(src2_val), .src2_tag(src2_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .ret_req(ret_req), .ret_fire(ret_fire)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance to just after the next rising edge and return inputs to idle.
  task automatic tick();
    @(posedge clk);
    #1;
    disp_valid = 0; wb_valid = 0; ret_req = 0;
  endtask

  task automatic dispatch(input int dst);
    disp_valid = 1; disp_dst = AW'(dst);
  endtask

  task automatic writeback(input int tag, input int data);
    wb_valid = 1; wb_tag = BW'(tag); wb_data = DATA_W'(data);
  endtask

  task automatic t_reset();
    tick();
    disp_src1 = 3; disp_src2 = 0; #1;
    chk("R1 stall", int'(disp_stall), 0);
    chk("R1 rdy", int'(src1_rdy), 1);
    chk("R1 val", int'(src1_val), 0);
  endtask

  task automatic t_basic();
    tick();
    dispatch(1); disp_src1 = 1; disp_src2 = 2; #1;
    chk("R2 first tag", int'(disp_tag), 0);
    chk("R11 own dst unseen rdy", int'(src1_rdy), 1);
    chk("R11 own dst unseen val", int'(src1_val), 0);
    tick();
    disp_src1 = 1; #1;
    chk("R4 rdy", int'(src1_rdy), 0);
    chk("R4 tag", int'(src1_tag), 0);
    writeback(0, 16'h1111); #1;
    chk("R6 bypass rdy", int'(src1_rdy), 1);
    chk("R6 bypass val", int'(src1_val), 16'h1111);
    tick(); #1;
    chk("R5 rdy", int'(src1_rdy), 1);
    chk("R5 val", int'(src1_val), 16'h1111);
    ret_req = 1; #1;
    chk("R9 fire", int'(ret_fire), 1);
    tick(); #1;
    chk("R7 arch rdy", int'(src1_rdy), 1);
    chk("R7 arch val", int'(src1_val), 16'h1111);
    chk("R7 arch tag", int'(src1_tag), 0);
  endtask

  task automatic t_younger();
    tick();
    dispatch(2); #1;
    chk("R2 tag1", int'(disp_tag), 1);
    tick();
    dispatch(2); #1;
    chk("R2 tag2", int'(disp_tag), 2);
    tick();
    writeback(1, 16'h2222); disp_src1 = 2; #1;
    chk("R8 newer tag", int'(src1_tag), 2);
    chk("R8 not ready", int'(src1_rdy), 0);
    tick();
    ret_req = 1; #1;
    chk("R9 fire older", int'(ret_fire), 1);
    tick();
    disp_src1 = 2; #1;
    chk("R10 younger kept rdy", int'(src1_rdy), 0);
    chk("R10 younger kept tag", int'(src1_tag), 2);
    writeback(2, 16'h3333);
    tick();
    ret_req = 1; #1;
    chk("R9 fire younger", int'(ret_fire), 1);
    tick(); #1;
    chk("R9 committed val", int'(src1_val), 16'h3333);
    chk("R9 committed rdy", int'(src1_rdy), 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < NUM_BUF; i++) begin
      tick();
      dispatch(3 + i); #1;
      chk("R2 wrap tag", int'(disp_tag), (3 + i) % NUM_BUF);
      chk("R3 no stall yet", int'(disp_stall), 0);
    end
    tick(); #1;
    chk("R3 stall when full", int'(disp_stall), 1);
    dispatch(7);
    tick();
    disp_src1 = 7; disp_src2 = 1; #1;
    chk("R3 ignored dispatch rdy", int'(src1_rdy), 1);
    chk("R3 ignored dispatch val", int'(src1_val), 0);
    chk("R3 still stalled", int'(disp_stall), 1);
    chk("R10 cleared entry rdy", int'(src2_rdy), 1);
    chk("R10 cleared entry val", int'(src2_val), 16'h1111);
    ret_req = 1; #1;
    chk("R9 head unfinished", int'(ret_fire), 0);
    for (int i = 0; i < NUM_BUF; i++) begin
      tick();
      writeback((3 + i) % NUM_BUF, 16'hA000 + i);
    end
    for (int i = 0; i < NUM_BUF; i++) begin
      tick();
      ret_req = 1; #1;
      chk("R9 drain fire", int'(ret_fire), 1);
    end
    tick();
    disp_src1 = 3; disp_src2 = 6; #1;
    chk("R3 stall released", int'(disp_stall), 0);
    chk("R9 r3 val", int'(src1_val), 16'hA000);
    chk("R9 r6 val", int'(src2_val), 16'hA003);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_younger();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule